// File: doc/BRIEF.md
# Graphics RAM Block-Write Unit

This block models the column storage of a graphics memory that can fill a group of columns in one step. A color register is loaded ahead of time. A later block-write command then stores that color into up to eight neighbouring columns of one bank at the command's clock edge. The command carries no write data. Instead, the low bits of the data bus act as a per-column enable, so that chosen columns in the group keep their old words.

The command pins are decoded at every rising edge. There are two recognised commands: a color-register load and a block write. Every other pin combination leaves both the array and the color register untouched. A separate read port returns the word stored in any column of any bank, so that the results of block writes can be checked.

Top module: `gbw_block_write_ram`

## Requirements
- R1: A block write is accepted at a rising edge when row_strobe_n=1, col_strobe_n=0, wr_en_n=0, func_sel=1 and cmd_addr[9]=0. It completes at that single edge, with no follow-on cycles.
- R2: A block write targets bank bank_sel and the eight-column group cmd_addr[7:3]. The group covers columns {cmd_addr[7:3], 3'd0} through {cmd_addr[7:3], 3'd7}. cmd_addr[2:0] has no effect.
- R3: dq_in[i] = 1 enables column {cmd_addr[7:3], i} for i in 0..7. dq_in bits 8 and above have no effect on a block write.
- R4: A column in the group whose dq_in bit is 0 keeps its previous word. Columns outside the group are unchanged.
- R5: Every enabled column receives the color register value, not the word on dq_in.
- R6: A color load is accepted when row_strobe_n=0, col_strobe_n=1, wr_en_n=0, func_sel=1. It stores dq_in into the color register, and a block write at the very next edge already uses the new value.
- R7: Reset (synchronous, active high) clears the color register to zero. A block write issued before any load therefore stores zeros.
- R8: Any other pin combination writes no column and leaves the color register unchanged. This includes a block write with cmd_addr[9]=1, or either command with func_sel=0.
- R9: The word of column rd_col in bank rd_bank, sampled at a rising edge, appears on rd_data after that edge. If the same edge writes that column, the read returns the word held before the write.
- R10: The banks are independent: a block write to one bank leaves every column of the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the color register |
| row_strobe_n | input | 1 | Row strobe command pin, active low |
| col_strobe_n | input | 1 | Column strobe command pin, active low |
| wr_en_n | input | 1 | Write command pin, active low |
| func_sel | input | 1 | Special-function select pin, high for color load and block write |
| bank_sel | input | 1 | Bank addressed by a block write |
| cmd_addr | input | 10 | Command address; bits 7:3 give the column group, bit 9 qualifies a block write |
| dq_in | input | 32 | Color value for a load, column-enable mask for a block write |
| rd_bank | input | 1 | Bank of the readback column |
| rd_col | input | 8 | Readback column |
| rd_data | output | 32 | Word stored in the addressed column, one edge later |

## Verification
Commands take effect at the rising edge that samples them. A loaded color reaches a block write at the next edge. The bench drives pins on falling edges and shows this by issuing a load and a block write in consecutive cycles. Readback data is due one edge after the read address is presented. Every check therefore sets rd_bank and rd_col on a falling edge and compares rd_data at the following falling edge. The read-during-write check samples at that same point, where the old word must still be visible, and then repeats the read one cycle later to see the new word.

// File: rtl/gbw_pkg.sv
package gbw_pkg;
  localparam int unsigned GBW_LANES = 8;

  typedef enum logic [1:0] {
    CMD_IDLE       = 2'd0,
    CMD_COLOR_LOAD = 2'd1,
    CMD_BLOCK_WR   = 2'd2
  } gbw_cmd_e;
endpackage

// File: rtl/gbw_cmd_decode.sv
module gbw_cmd_decode
  import gbw_pkg::*;
(
  input  logic     row_strobe_n,
  input  logic     col_strobe_n,
  input  logic     wr_en_n,
  input  logic     func_sel,
  input  logic     qual_bit,
  output gbw_cmd_e cmd
);
  always_comb begin
    cmd = CMD_IDLE;
    if (func_sel && !wr_en_n) begin
      if (row_strobe_n && !col_strobe_n && !qual_bit)
        cmd = CMD_BLOCK_WR;
      else if (!row_strobe_n && col_strobe_n)
        cmd = CMD_COLOR_LOAD;
    end
  end
endmodule

// File: rtl/gbw_color_reg.sv
module gbw_color_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] color_q
);
  always_ff @(posedge clk) begin
    if (rst)
      color_q <= '0;
    else if (load)
      color_q <= load_data;
  end

  assert_color_load_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> color_q == $past(load_data));

  assert_color_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(color_q));

  assert_color_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> color_q == '0);
endmodule

// File: rtl/gbw_lane_mem.sv
module gbw_lane_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 6,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/gbw_block_write_ram.sv
module gbw_block_write_ram
  import gbw_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned QUAL_BIT  = 9,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_strobe_n,
  input  logic              col_strobe_n,
  input  logic              wr_en_n,
  input  logic              func_sel,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned LANES  = GBW_LANES;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned BLK_W  = COL_W - LANE_W;
  localparam int unsigned LAW    = BANK_W + BLK_W;

  gbw_cmd_e          cmd;
  logic [DATA_W-1:0] color_q;
  logic [LANES-1:0]  lane_we;
  logic [LAW-1:0]    wr_index;
  logic [LAW-1:0]    rd_index;
  logic [LANE_W-1:0] rd_lane_q;
  logic [DATA_W-1:0] lane_q [LANES];
  logic              unused_bits;

  assign unused_bits = ^{cmd_addr, dq_in};

  gbw_cmd_decode u_dec (
    .row_strobe_n (row_strobe_n),
    .col_strobe_n (col_strobe_n),
    .wr_en_n      (wr_en_n),
    .func_sel     (func_sel),
    .qual_bit     (cmd_addr[QUAL_BIT]),
    .cmd          (cmd)
  );

  gbw_color_reg #(.DATA_W(DATA_W)) u_color (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd == CMD_COLOR_LOAD),
    .load_data (dq_in),
    .color_q   (color_q)
  );

  assign wr_index = {bank_sel, cmd_addr[COL_W-1:LANE_W]};
  assign rd_index = {rd_bank, rd_col[COL_W-1:LANE_W]};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = (cmd == CMD_BLOCK_WR) && !rst && dq_in[g];

    gbw_lane_mem #(.DATA_W(DATA_W), .AW(LAW)) u_mem (
      .clk   (clk),
      .we    (lane_we[g]),
      .waddr (wr_index),
      .wdata (color_q),
      .raddr (rd_index),
      .rdata (lane_q[g])
    );
  end

  always_ff @(posedge clk) begin
    rd_lane_q <= rd_col[LANE_W-1:0];
  end

  assign rd_data = lane_q[rd_lane_q];

  assert_we_needs_decode_R1: assert property (@(posedge clk) disable iff (rst)
    (|lane_we) |-> (row_strobe_n && !col_strobe_n && !wr_en_n && func_sel
                    && !cmd_addr[QUAL_BIT]));

  assert_we_within_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (|lane_we) |-> ((lane_we & ~dq_in[LANES-1:0]) == '0));

  assert_no_write_on_load_R8: assert property (@(posedge clk) disable iff (rst)
    (!row_strobe_n) |-> (lane_we == '0));
endmodule

// File: tb/sim_gbw_block_write_ram.sv
`timescale 1ns/1ps
module sim_gbw_block_write_ram;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        row_strobe_n = 1'b1, col_strobe_n = 1'b1, wr_en_n = 1'b1, func_sel = 1'b0;
  logic        bank_sel = 1'b0;
  logic [9:0]  cmd_addr = '0;
  logic [31:0] dq_in = '0;
  logic        rd_bank = 1'b0;
  logic [7:0]  rd_col = '0;
  logic [31:0] rd_data;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] exp_mem [2][256];
  logic [31:0] color_m = '0;

  always #4 clk = ~clk;

  gbw_block_write_ram u0 (
    .clk(clk), .rst(rst), .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
    .wr_en_n(wr_en_n), .func_sel(func_sel), .bank_sel(bank_sel), .cmd_addr(cmd_addr),
    .dq_in(dq_in), .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data)
  );

  function automatic logic [9:0] mk_addr(input logic q, input logic [4:0] blk, input logic [2:0] lo);
    return {q, 1'b0, blk, lo};
  endfunction

  task automatic set_pins(input logic r, input logic c, input logic w, input logic f,
                          input logic b, input logic [9:0] a, input logic [31:0] d);
    row_strobe_n = r; col_strobe_n = c; wr_en_n = w; func_sel = f;
    bank_sel = b; cmd_addr = a; dq_in = d;
  endtask

  task automatic set_nop();
    set_pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic cmd_once(input logic r, input logic c, input logic w, input logic f,
                          input logic b, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    set_pins(r, c, w, f, b, a, d);
    @(negedge clk);
    set_nop();
  endtask

  task automatic model_bw(input logic b, input logic [4:0] blk, input logic [31:0] d);
    for (int i = 0; i < 8; i++)
      if (d[i]) exp_mem[b][{blk, i[2:0]}] = color_m;
  endtask

  task automatic block_write(input logic b, input logic [4:0] blk, input logic [2:0] lo,
                             input logic [31:0] d);
    cmd_once(1'b1, 1'b0, 1'b0, 1'b1, b, mk_addr(1'b0, blk, lo), d);
    model_bw(b, blk, d);
  endtask

  task automatic color_load(input logic [31:0] c);
    cmd_once(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, c);
    color_m = c;
  endtask

  task automatic compare(input string tag, input logic [31:0] got, input logic [31:0] want);
    vectors++;
    if (got !== want) begin
      miscompares++;
      $display("FAIL %s: got %08h expected %08h", tag, got, want);
    end
  endtask

  task automatic check_col(input logic b, input logic [7:0] col, input string tag);
    @(negedge clk);
    rd_bank = b; rd_col = col;
    @(negedge clk);
    compare($sformatf("%s bank %0d col %0d", tag, b, col), rd_data, exp_mem[b][col]);
  endtask

  task automatic check_block(input logic b, input logic [4:0] blk, input string tag);
    for (int i = 0; i < 8; i++) check_col(b, {blk, i[2:0]}, tag);
  endtask

  // R7: after reset the color is zero, so a full fill stores zeros everywhere
  task automatic t_reset_fill();
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 32; k++) block_write(b[0], k[4:0], 3'd0, 32'h0000_00FF);
    check_col(1'b0, 8'd0, "R7 reset color zero");
    check_col(1'b1, 8'd255, "R7 reset color zero");
    check_col(1'b0, 8'd77, "R7 reset color zero");
  endtask

  // R1 R2 R5 R6: load then block write on the very next edge, dq carries unrelated data
  task automatic t_load_and_fill();
    @(negedge clk);
    set_pins(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, 32'hCAFE_1234);
    color_m = 32'hCAFE_1234;
    @(negedge clk);
    set_pins(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, mk_addr(1'b0, 5'd5, 3'd6), 32'h5A5A_A5FF);
    model_bw(1'b0, 5'd5, 32'h5A5A_A5FF);
    @(negedge clk);
    set_nop();
    check_block(1'b0, 5'd5, "R1 R2 R5 R6 full block");
    check_col(1'b0, 8'd39, "R4 below group");
    check_col(1'b0, 8'd48, "R4 above group");
  endtask

  // R3 R4: partial mask, upper dq bits set but must be ignored
  task automatic t_mask();
    color_load(32'h0BAD_F00D);
    block_write(1'b0, 5'd5, 3'd0, 32'hFFFF_FFA5);
    check_block(1'b0, 5'd5, "R3 R4 mask A5");
    block_write(1'b0, 5'd5, 3'd3, 32'hFFFF_FF00);
    check_block(1'b0, 5'd5, "R3 R4 mask zero");
  endtask

  // R8: non-matching combinations touch neither the array nor the color register
  task automatic t_ignored();
    cmd_once(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, mk_addr(1'b1, 5'd5, 3'd0), 32'h0000_00FF);
    cmd_once(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, mk_addr(1'b0, 5'd5, 3'd0), 32'h0000_00FF);
    cmd_once(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, mk_addr(1'b0, 5'd5, 3'd0), 32'h0000_00FF);
    check_block(1'b0, 5'd5, "R8 array untouched");
    cmd_once(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 32'h1111_2222);
    cmd_once(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, 32'h3333_4444);
    block_write(1'b0, 5'd6, 3'd0, 32'h0000_00FF);
    check_col(1'b0, 8'd48, "R8 color unchanged");
    check_col(1'b0, 8'd55, "R8 color unchanged");
  endtask

  // R10: same group in bank 1 leaves bank 0 alone
  task automatic t_banks();
    color_load(32'h7777_0001);
    block_write(1'b1, 5'd5, 3'd0, 32'h0000_003C);
    check_block(1'b1, 5'd5, "R10 bank1 written");
    check_block(1'b0, 5'd5, "R10 bank0 kept");
  endtask

  // R2 R4: edge groups and their neighbours
  task automatic t_edges();
    color_load(32'hDEAD_BEEF);
    block_write(1'b0, 5'd31, 3'd7, 32'h0000_0081);
    block_write(1'b1, 5'd0, 3'd0, 32'h0000_0018);
    check_block(1'b0, 5'd31, "R2 top group");
    check_col(1'b0, 8'd247, "R4 neighbour of top group");
    check_block(1'b1, 5'd0, "R2 bottom group");
    check_col(1'b1, 8'd8, "R4 neighbour of bottom group");
  endtask

  // R9: read on the same edge as the write returns the old word
  task automatic t_read_during_write();
    logic [31:0] old_word;
    color_load(32'h0F0F_F0F0);
    old_word = exp_mem[0][8'd98];
    @(negedge clk);
    set_pins(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, mk_addr(1'b0, 5'd12, 3'd0), 32'h0000_0004);
    rd_bank = 1'b0; rd_col = 8'd98;
    @(negedge clk);
    set_nop();
    compare("R9 read during write old word", rd_data, old_word);
    model_bw(1'b0, 5'd12, 32'h0000_0004);
    @(negedge clk);
    compare("R9 next read new word", rd_data, exp_mem[0][8'd98]);
    check_col(1'b0, 8'd99, "R9 R4 lane neighbour");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_fill();
    t_load_and_fill();
    t_mask();
    t_ignored();
    t_banks();
    t_edges();
    t_read_during_write();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule